// File: doc/BRIEF.md
# Masked Interrupt Aggregation Controller

This block gathers a set of interrupt request lines into one pending register and drives a single upstream interrupt line. Device logic raises requests by presenting a set vector. It retires requests by presenting a clear vector. Both vectors act on the pending register in the clock where they are presented.

A narrow configuration write port loads two mask registers. The primary mask decides which pending bits may raise the upstream line. The auxiliary mask is stored and visible on an output, but it gates nothing.

The upstream line is a registered "already interrupting" flag. It is raised at most once, when a post or a primary-mask write leaves an enabled pending bit. It is lowered only by a clear that leaves no enabled pending bit. A mask write can therefore raise the line, but can never drop it. There is no priority, no vector and no acknowledge protocol.

Top module: `irq_merge_ctrl`

## Requirements
- R1: A nonzero `set_vec` ORs its bits into `pend_o`, visible one clock later.
- R2: A nonzero `clr_vec` removes its bits from `pend_o` (AND with the inverted vector), visible one clock later.
- R3: When `set_vec` and `clr_vec` are both presented in one clock, the clear is applied after the post, so a bit present in both ends up clear.
- R4: One clock after a post or a primary-mask write (`cfg_we`=1, `cfg_sel`=0) that leaves (pending AND primary mask) nonzero, `irq_o` is high. A post of bits that are not enabled leaves `irq_o` low.
- R5: While `irq_o` is high, further posts keep it high; the line is raised once and does not pulse.
- R6: One clock after a nonzero clear that leaves (pending AND primary mask) zero, `irq_o` is low. A clear that leaves an enabled bit pending keeps `irq_o` high. This holds even when the mask, not the clear, removed the last enabled bit.
- R7: A primary-mask write never lowers `irq_o`, including a write of all zeros.
- R8: A write with `cfg_sel`=1 loads the auxiliary mask, shown on `aux_mask_o` one clock later. It changes neither `irq_o` nor `pend_o`.
- R9: While `rst_n` is low, `pend_o`, both masks and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_vec | input | WIDTH | Request bits to post this clock |
| clr_vec | input | WIDTH | Request bits to retire this clock |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | 1 | Mask select: 0 primary, 1 auxiliary |
| cfg_data | input | WIDTH | Mask write data |
| pend_o | output | WIDTH | Pending request register |
| aux_mask_o | output | WIDTH | Stored auxiliary mask |
| irq_o | output | 1 | Registered upstream interrupt |

## Verification
The bench writes the primary mask to zero while `irq_o` is high. A design that recomputes the line from the masked pending bits would drop it there; this design must keep it high. It then clears a bit while other pending bits remain enabled, and also while only disabled bits remain. A design that keys the drop on the pending register being empty, rather than on the enabled bits, would keep the line high wrongly or drop it wrongly.

Same-clock post and clear of one bit is driven to catch a design that gives the post priority. Auxiliary-mask writes are interleaved to catch a design that gates the line with the wrong mask. A seeded random phase checks pending bits and line state against a bench model on every clock.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

   typedef enum logic {
      SEL_PRIMARY = 1'b0,
      SEL_AUX     = 1'b1
   } mask_sel_e;

   localparam int unsigned MASK_COUNT = 2;

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic [WIDTH-1:0] clr_vec,
   output logic [WIDTH-1:0] pend_nxt,
   output logic [WIDTH-1:0] pend_q
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      // clear is ordered after post within the same clock
      assign pend_nxt[b] = (pend_q[b] | set_vec[b]) & ~clr_vec[b];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q[b] <= 1'b0;
         else        pend_q[b] <= pend_nxt[b];
      end
   end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned WIDTH     = 8,
   parameter int unsigned NUM_MASKS = 2,
   localparam int unsigned SEL_W    = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [SEL_W-1:0]                sel,
   input  logic [WIDTH-1:0]                wdata,
   output logic [NUM_MASKS-1:0][WIDTH-1:0] mask_nxt,
   output logic [NUM_MASKS-1:0][WIDTH-1:0] mask_q
);

   if (NUM_MASKS < 1) begin : g_bad_count
      $error("irq_mask_bank: NUM_MASKS must be at least 1");
   end

   for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
      logic hit;
      assign hit         = we && (sel == SEL_W'(m));
      assign mask_nxt[m] = hit ? wdata : mask_q[m];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mask_q[m] <= '0;
         else        mask_q[m] <= mask_nxt[m];
      end
   end

endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pend_nxt,
   input  logic [WIDTH-1:0] prim_nxt,
   input  logic             raise_evt,
   input  logic             clear_evt,
   output logic             flag_q
);

   logic enabled_any;
   logic flag_d;

   assign enabled_any = |(pend_nxt & prim_nxt);

   always_comb begin
      flag_d = flag_q;
      if (raise_evt && enabled_any && !flag_q) begin
         flag_d = 1'b1;
      end else if (clear_evt && !enabled_any) begin
         flag_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
   import irq_merge_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic [WIDTH-1:0] clr_vec,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [WIDTH-1:0] cfg_data,
   output logic [WIDTH-1:0] pend_o,
   output logic [WIDTH-1:0] aux_mask_o,
   output logic             irq_o
);

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("irq_merge_ctrl: WIDTH must lie in 1..32");
   end

   localparam int unsigned PRIM_IDX = int'(SEL_PRIMARY);
   localparam int unsigned AUX_IDX  = int'(SEL_AUX);

   logic [WIDTH-1:0]                 pend_nxt;
   logic [WIDTH-1:0]                 pend_q;
   logic [MASK_COUNT-1:0][WIDTH-1:0] mask_nxt;
   logic [MASK_COUNT-1:0][WIDTH-1:0] mask_q;
   logic                             prim_wr;
   logic                             raise_evt;
   logic                             clear_evt;
   logic                             flag_q;

   irq_pend_reg #(.WIDTH(WIDTH)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_vec  (clr_vec),
      .pend_nxt (pend_nxt),
      .pend_q   (pend_q)
   );

   irq_mask_bank #(.WIDTH(WIDTH), .NUM_MASKS(MASK_COUNT)) u_masks (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .sel      (cfg_sel),
      .wdata    (cfg_data),
      .mask_nxt (mask_nxt),
      .mask_q   (mask_q)
   );

   assign prim_wr   = cfg_we && (cfg_sel == SEL_PRIMARY);
   assign raise_evt = (|set_vec) || prim_wr;
   assign clear_evt = |clr_vec;

   irq_flag_unit #(.WIDTH(WIDTH)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_nxt  (pend_nxt),
      .prim_nxt  (mask_nxt[PRIM_IDX]),
      .raise_evt (raise_evt),
      .clear_evt (clear_evt),
      .flag_q    (flag_q)
   );

   assign pend_o     = pend_q;
   assign aux_mask_o = mask_q[AUX_IDX];
   assign irq_o      = flag_q;

endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] set_vec,
   input logic [WIDTH-1:0] clr_vec,
   input logic             cfg_we,
   input logic             cfg_sel,
   input logic [WIDTH-1:0] pend_o,
   input logic [WIDTH-1:0] aux_mask_o,
   input logic             irq_o
);

   a_r1_post_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_vec & ~clr_vec)) |=> ((pend_o & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));

   // R2 and R3: cleared bits are gone, whatever was posted alongside
   a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_vec) |=> ((pend_o & $past(clr_vec)) == '0));

   a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past((|set_vec) || (cfg_we && !cfg_sel)));

   a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(|clr_vec));

   a_r7_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && cfg_we && !cfg_sel && clr_vec == '0) |=> irq_o);

   a_r8_aux_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel && set_vec == '0 && clr_vec == '0)
      |=> ($stable(irq_o) && $stable(pend_o)));

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r9_reset_low: assert (!irq_o && pend_o == '0 && aux_mask_o == '0);
      end
   end

endmodule

bind irq_merge_ctrl irq_merge_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .set_vec    (set_vec),
   .clr_vec    (clr_vec),
   .cfg_we     (cfg_we),
   .cfg_sel    (cfg_sel),
   .pend_o     (pend_o),
   .aux_mask_o (aux_mask_o),
   .irq_o      (irq_o)
);

// File: tb/irq_merge_ctrl_tb.sv
module irq_merge_ctrl_tb;

   localparam int W     = 8;
   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic [W-1:0] set_vec = '0;
   logic [W-1:0] clr_vec = '0;
   logic         cfg_we = 1'b0;
   logic         cfg_sel = 1'b0;
   logic [W-1:0] cfg_data = '0;
   logic [W-1:0] pend_o;
   logic [W-1:0] aux_mask_o;
   logic         irq_o;

   irq_merge_ctrl #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .pend_o(pend_o), .aux_mask_o(aux_mask_o), .irq_o(irq_o)
   );

   always #(CLK_P/2) clk = ~clk;

   typedef struct {
      int           due;
      logic         irq;
      logic [W-1:0] pend;
      logic [W-1:0] aux;
      string        tag;
   } exp_t;

   exp_t   sb[$];
   int     cyc = 0;
   int     n_chk = 0;
   int     n_bad = 0;
   bit     done = 1'b0;

   // bench model state
   logic [W-1:0] m_pend = '0;
   logic [W-1:0] m_prim = '0;
   logic [W-1:0] m_aux  = '0;
   logic         m_irq  = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         n_chk++;
         if (irq_o !== e.irq || pend_o !== e.pend || aux_mask_o !== e.aux) begin
            n_bad++;
            $display("FAIL %s: irq=%0b pend=%02h aux=%02h expected irq=%0b pend=%02h aux=%02h",
                     e.tag, irq_o, pend_o, aux_mask_o, e.irq, e.pend, e.aux);
         end
      end
   end

   task automatic step(input logic [W-1:0] s, input logic [W-1:0] c,
                       input logic we, input logic sel, input logic [W-1:0] d,
                       input string tag);
      logic [W-1:0] np;
      logic [W-1:0] nm;
      logic         en;
      logic         ni;
      exp_t         e;
      @(negedge clk);
      set_vec = s; clr_vec = c; cfg_we = we; cfg_sel = sel; cfg_data = d;
      np = (m_pend | s) & ~c;
      nm = (we && !sel) ? d : m_prim;
      en = |(np & nm);
      ni = m_irq;
      if (((|s) || (we && !sel)) && en) ni = 1'b1;
      else if ((|c) && !en)            ni = 1'b0;
      m_pend = np; m_prim = nm; m_irq = ni;
      if (we && sel) m_aux = d;
      e.due = cyc + 1; e.irq = m_irq; e.pend = m_pend; e.aux = m_aux; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         finish_run();
      end
   end

   initial begin
      logic [15:0] lf;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      n_chk++;
      if (irq_o !== 1'b0 || pend_o !== '0 || aux_mask_o !== '0) begin
         n_bad++;
         $display("FAIL R9: irq=%0b pend=%02h aux=%02h expected 0/00/00", irq_o, pend_o, aux_mask_o);
      end
      rst_n = 1'b1;

      step(8'h01, 8'h00, 0, 0, 8'h00, "R1 post, mask zero");
      step(8'h00, 8'h00, 1, 0, 8'h01, "R4 mask write raises");
      step(8'h00, 8'h00, 1, 0, 8'h00, "R7 mask zero keeps line");
      step(8'h00, 8'h00, 1, 1, 8'hFF, "R8 aux write inert");
      step(8'h00, 8'h01, 0, 0, 8'h00, "R6 clear drops line");
      step(8'h00, 8'h00, 1, 0, 8'h0F, "R4 mask write no pending");
      step(8'h02, 8'h00, 0, 0, 8'h00, "R4 post raises");
      step(8'h04, 8'h00, 0, 0, 8'h00, "R5 second post holds");
      step(8'h00, 8'h02, 0, 0, 8'h00, "R6 clear with enabled left");
      step(8'h10, 8'h10, 0, 0, 8'h00, "R3 post and clear same bit");
      step(8'h08, 8'h04, 0, 0, 8'h00, "R3 post and clear differ");
      step(8'h00, 8'h08, 0, 0, 8'h00, "R2 clear last enabled");
      step(8'h80, 8'h00, 0, 0, 8'h00, "R4 disabled post stays low");
      step(8'h00, 8'h00, 1, 1, 8'h80, "R8 aux enables nothing");
      step(8'h01, 8'h00, 0, 0, 8'h00, "R5 raise again");
      step(8'h00, 8'h00, 1, 0, 8'h00, "R7 mask cleared while high");
      step(8'h00, 8'h80, 0, 0, 8'h00, "R6 clear disabled bit drops");
      step(8'h00, 8'h00, 0, 0, 8'h00, "R2 idle");

      lf = 16'hACE1;
      for (int i = 0; i < 200; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[7:0] & lf[15:8], (lf[3:0] == 4'h5) ? lf[15:8] : (lf[11:4] & lf[6:0]),
              lf[2] & lf[9], lf[5], lf[12:5], "R6 random mix");
      end
      step(8'h00, 8'h00, 0, 0, 8'h00, "R1 drain");
      repeat (3) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule